// File: doc/BRIEF.md
# Link Retrain Sequencer

This block brings a point-to-point serial link up to second-generation speed after reset. A one-cycle start pulse launches a fixed sequence. The sequencer first checks the speed capability reported by the far end. It then asks for a retrain through a self-clearing control bit and waits for the training-in-progress flag in the link-status word to drop. It performs this retrain-and-wait step twice, then reports the negotiated speed and lane width and pulses done.

The register interface is an internal register file. It holds the control word, a 3-bit target-speed field and an 8-bit fast-training-sequence count. A stub link partner models the far side. When it sees a retrain request it raises the training flag, holds the flag for a programmable number of cycles, and then publishes a new status word. The speed in that word comes from the target field. The width comes from the `partner_width` input.

Each wait has its own watchdog counter. If training does not finish within a parameterised number of cycles, the sequencer abandons the run and flags an error.

Top module: `link_retrain_seq`

## Requirements
- R1: After reset, the outputs are `busy`=0, `done`=0 and `error`=0, `final_speed`=0 and `final_width`=0, `target_speed`=1 and `fts_count`=0x00.
- R2: During the configuration step of a run, the target speed is set to 2 and `fts_count` is set to 0x3A only when `peer_cap` equals 2. For any other `peer_cap` value, both fields keep their previous values.
- R3: A retrain request sets bit 5 of the link-control word, and that bit clears by itself one cycle later.
- R4: A pass ends only in a cycle in which bit 11 of the link-status word reads low. With a partner delay of D, the training flag stays high for D+1 cycles. `done` is seen 10+2·D clock edges after the edge that samples start, counting that edge as the first.
- R5: Exactly two retrain passes run. The reported width is the one the partner published at the end of the second pass, even if the partner width changed after the first pass.
- R6: In the link-status word, bits [3:0] hold the speed and bits [8:4] hold the lane width. `final_speed` and `final_width` report those fields, so a successful run reports the current target speed.
- R7: If the flag is still high in the TIMEOUT-th consecutive wait cycle of a pass, the run aborts. `error` is set, `done` pulses, and `final_speed`=0 and `final_width`=0. `done` is seen 4+TIMEOUT edges after start when the first pass times out.
- R8: A start pulse that arrives while `busy` is high is ignored, so the run timing and results are unchanged.
- R9: `done` is high for exactly one cycle. `final_speed`, `final_width` and `error` hold their values until the next accepted start.
- R10: `busy` is high from the cycle after an accepted start through the `done` cycle, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches the sequence |
| peer_cap | input | 4 | Speed capability reported by the far end |
| partner_delay | input | DLY_W | Cycles the stub partner holds the training flag after the first |
| partner_width | input | 5 | Lane width the stub partner publishes when training ends |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| error | output | 1 | Wait timeout occurred in the last run |
| final_speed | output | 4 | Speed field after the second pass |
| final_width | output | 5 | Width field after the second pass |
| target_speed | output | 3 | Target-speed field of the register file |
| fts_count | output | 8 | Fast-training-sequence count field |

## Verification
The assertions check the per-cycle rules on every cycle. These are: the one-cycle `done` pulse, the self-clearing retrain bit, the rule that the target and FTS fields can only move to their Gen2 values, `error` rising only together with `done`, the training flag being low at a successful finish, and the results holding steady while idle. The bench scenarios cover what needs a whole run. They measure the exact latency for many partner delays and check the timeout edge at TIMEOUT-2 versus TIMEOUT-1. They show that a width change between passes wins, that a start during a run is ignored, and that the capability gate depends on the history of earlier runs.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    localparam int CTRL_W      = 16;
    localparam int STAT_W      = 16;
    localparam int RETRAIN_POS = 5;
    localparam int TRAIN_POS   = 11;
    localparam int SPD_LSB     = 0;
    localparam int SPD_W       = 4;
    localparam int WID_LSB     = 4;
    localparam int WID_W       = 5;
    localparam int TGT_W       = 3;
    localparam int FTS_W       = 8;

    localparam logic [TGT_W-1:0] TGT_GEN1 = 3'd1;
    localparam logic [TGT_W-1:0] TGT_GEN2 = 3'd2;
    localparam logic [3:0]       CAP_GEN2 = 4'd2;
    localparam logic [FTS_W-1:0] FTS_RST  = 8'h00;
    localparam logic [FTS_W-1:0] FTS_GEN2 = 8'h3A;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CFG,
        ST_KICK,
        ST_HOLD,
        ST_WAIT,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic             train;
        logic [WID_W-1:0] width;
        logic [SPD_W-1:0] speed;
    } link_stat_t;

    function automatic logic [STAT_W-1:0] pack_stat(input link_stat_t s);
        logic [STAT_W-1:0] w;
        w = '0;
        w[TRAIN_POS]                 = s.train;
        w[WID_LSB +: WID_W]          = s.width;
        w[SPD_LSB +: SPD_W]          = s.speed;
        return w;
    endfunction

    function automatic link_stat_t unpack_stat(input logic [STAT_W-1:0] w);
        link_stat_t s;
        s.train = w[TRAIN_POS];
        s.width = w[WID_LSB +: WID_W];
        s.speed = w[SPD_LSB +: SPD_W];
        return s;
    endfunction

    function automatic logic retrain_bit(input logic [CTRL_W-1:0] w);
        return w[RETRAIN_POS];
    endfunction

endpackage

// File: rtl/lrs_regfile.sv
module lrs_regfile
    import lrs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              retrain_req,
    input  logic              gen2_we,
    output logic [CTRL_W-1:0] ctrl_word,
    output logic [TGT_W-1:0]  target_speed,
    output logic [FTS_W-1:0]  fts_count
);
    logic             rtr_q;
    logic [TGT_W-1:0] tgt_q;
    logic [FTS_W-1:0] fts_q;

    // retrain bit lives only for the cycle after the request
    always_ff @(posedge clk) begin
        if (rst) begin
            rtr_q <= 1'b0;
            tgt_q <= TGT_GEN1;
            fts_q <= FTS_RST;
        end else begin
            rtr_q <= retrain_req;
            if (gen2_we) begin
                tgt_q <= TGT_GEN2;
                fts_q <= FTS_GEN2;
            end
        end
    end

    always_comb begin
        ctrl_word              = '0;
        ctrl_word[RETRAIN_POS] = rtr_q;
    end

    assign target_speed = tgt_q;
    assign fts_count    = fts_q;
endmodule

// File: rtl/lrs_partner_stub.sv
module lrs_partner_stub
    import lrs_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [TGT_W-1:0]  target_speed,
    input  logic [DLY_W-1:0]  delay,
    input  logic [WID_W-1:0]  lane_width,
    output logic [STAT_W-1:0] status_word
);
    link_stat_t       st_q;
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.train <= 1'b0;
            st_q.width <= '0;
            st_q.speed <= SPD_W'(TGT_GEN1);
            cnt_q      <= '0;
        end else if (retrain_bit(ctrl_word)) begin
            st_q.train <= 1'b1;
            cnt_q      <= delay;
        end else if (st_q.train) begin
            if (cnt_q == '0) begin
                st_q.train <= 1'b0;
                st_q.width <= lane_width;
                st_q.speed <= SPD_W'(target_speed);
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign status_word = pack_stat(st_q);
endmodule

// File: rtl/lrs_seq_fsm.sv
module lrs_seq_fsm
    import lrs_pkg::*;
#(
    parameter int TIMEOUT = 1024,
    parameter int PASSES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        peer_cap,
    input  logic [STAT_W-1:0] status_word,
    output logic              retrain_req,
    output logic              gen2_we,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [SPD_W-1:0]  final_speed,
    output logic [WID_W-1:0]  final_width
);
    localparam int TW = $clog2(TIMEOUT + 1);
    localparam int PW = (PASSES > 1) ? $clog2(PASSES) : 1;

    seq_state_e       state_q;
    logic [TW-1:0]    wcnt_q;
    logic [PW-1:0]    pass_q;
    logic             err_q;
    logic [SPD_W-1:0] spd_q;
    logic [WID_W-1:0] wid_q;
    link_stat_t       stat;

    assign stat = unpack_stat(status_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wcnt_q  <= '0;
            pass_q  <= '0;
            err_q   <= 1'b0;
            spd_q   <= '0;
            wid_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_CFG;
                    pass_q  <= '0;
                    err_q   <= 1'b0;
                    spd_q   <= '0;
                    wid_q   <= '0;
                end
                ST_CFG:  state_q <= ST_KICK;
                ST_KICK: state_q <= ST_HOLD;
                ST_HOLD: begin
                    state_q <= ST_WAIT;
                    wcnt_q  <= '0;
                end
                ST_WAIT: begin
                    if (!stat.train) begin
                        if (pass_q == PW'(PASSES - 1)) begin
                            spd_q   <= stat.speed;
                            wid_q   <= stat.width;
                            state_q <= ST_DONE;
                        end else begin
                            pass_q  <= pass_q + 1'b1;
                            state_q <= ST_KICK;
                        end
                    end else if (wcnt_q == TW'(TIMEOUT - 1)) begin
                        err_q   <= 1'b1;
                        state_q <= ST_DONE;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign retrain_req = (state_q == ST_KICK);
    assign gen2_we     = (state_q == ST_CFG) && (peer_cap == CAP_GEN2);
    assign busy        = (state_q != ST_IDLE);
    assign done        = (state_q == ST_DONE);
    assign error       = err_q;
    assign final_speed = spd_q;
    assign final_width = wid_q;
endmodule

// File: rtl/link_retrain_seq.sv
module link_retrain_seq
    import lrs_pkg::*;
#(
    parameter int DLY_W   = 8,
    parameter int TIMEOUT = 1024,
    parameter int PASSES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [3:0]       peer_cap,
    input  logic [DLY_W-1:0] partner_delay,
    input  logic [4:0]       partner_width,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic [3:0]       final_speed,
    output logic [4:0]       final_width,
    output logic [2:0]       target_speed,
    output logic [7:0]       fts_count
);
    logic              retrain_req;
    logic              gen2_we;
    logic [CTRL_W-1:0] ctrl_word;
    logic [STAT_W-1:0] status_word;

    lrs_seq_fsm #(.TIMEOUT(TIMEOUT), .PASSES(PASSES)) u_fsm (
        .clk(clk), .rst(rst), .start(start), .peer_cap(peer_cap),
        .status_word(status_word), .retrain_req(retrain_req),
        .gen2_we(gen2_we), .busy(busy), .done(done), .error(error),
        .final_speed(final_speed), .final_width(final_width)
    );

    lrs_regfile u_regs (
        .clk(clk), .rst(rst), .retrain_req(retrain_req), .gen2_we(gen2_we),
        .ctrl_word(ctrl_word), .target_speed(target_speed),
        .fts_count(fts_count)
    );

    lrs_partner_stub #(.DLY_W(DLY_W)) u_peer (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_word),
        .target_speed(target_speed), .delay(partner_delay),
        .lane_width(partner_width), .status_word(status_word)
    );
endmodule

// File: rtl/lrs_checker.sv
module lrs_checker
    import lrs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              error,
    input logic [3:0]        final_speed,
    input logic [4:0]        final_width,
    input logic [2:0]        target_speed,
    input logic [7:0]        fts_count,
    input logic [CTRL_W-1:0] ctrl_word,
    input logic [STAT_W-1:0] status_word
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    retrain_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_word[RETRAIN_POS] |=> !ctrl_word[RETRAIN_POS]);

    // R2
    fts_value_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(fts_count) |-> (fts_count == FTS_GEN2));

    // R2
    target_value_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(target_speed) |-> (target_speed == TGT_GEN2));

    // R7
    error_at_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> done);

    // R4
    flag_low_at_done_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !error) |-> !status_word[TRAIN_POS]);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(final_speed) && $stable(final_width) && $stable(error)));
endmodule

bind link_retrain_seq lrs_checker u_lrs_checker (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .error(error), .final_speed(final_speed), .final_width(final_width),
    .target_speed(target_speed), .fts_count(fts_count),
    .ctrl_word(ctrl_word), .status_word(status_word)
);

// File: tb/link_retrain_seq_bench.sv
module link_retrain_seq_bench;
    localparam int DLY_W = 8;
    localparam int TMO   = 64;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [3:0]       peer_cap = 4'd0;
    logic [DLY_W-1:0] partner_delay = '0;
    logic [4:0]       partner_width = 5'd0;
    logic             busy, done, error;
    logic [3:0]       final_speed;
    logic [4:0]       final_width;
    logic [2:0]       target_speed;
    logic [7:0]       fts_count;

    int checks = 0;
    int errors = 0;
    int exp_tgt = 1;
    int exp_fts = 0;
    bit wd_hit = 1'b0;

    always #4 clk = ~clk;

    link_retrain_seq #(.DLY_W(DLY_W), .TIMEOUT(TMO)) u_link_retrain_seq (
        .clk(clk), .rst(rst), .start(start), .peer_cap(peer_cap),
        .partner_delay(partner_delay), .partner_width(partner_width),
        .busy(busy), .done(done), .error(error), .final_speed(final_speed),
        .final_width(final_width), .target_speed(target_speed),
        .fts_count(fts_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_latency(input int d);
        return (d >= TMO - 1) ? (4 + TMO) : (10 + 2 * d);
    endfunction

    // one full run; inputs change only at negedges
    task automatic run(input int cap, input int d, input int w1, input int w2,
                       input int chg_at, input bit extra_start, input string tag);
        int  n = 0;
        bit  busy_ok = 1'b1;
        bit  err_exp;
        @(negedge clk);
        peer_cap      = 4'(cap);
        partner_delay = DLY_W'(d);
        partner_width = 5'(w1);
        start         = 1'b1;
        if (cap == 2) begin
            exp_tgt = 2;
            exp_fts = 8'h3A;
        end
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = 1'b0;
            if (extra_start && (n == 5)) start = 1'b1;
            if (n == chg_at) partner_width = 5'(w2);
            if (!busy) busy_ok = 1'b0;
            if (done || n > 4000) break;
        end
        err_exp = (d >= TMO - 1);
        chk({tag, " R4 latency"}, n, exp_latency(d));
        chk({tag, " R7 error"}, int'(error), int'(err_exp));
        chk({tag, " R10 busy"}, int'(busy_ok), 1);
        chk({tag, " R2 target"}, int'(target_speed), exp_tgt);
        chk({tag, " R2 fts"}, int'(fts_count), exp_fts);
        chk({tag, " R6 speed"}, int'(final_speed), err_exp ? 0 : exp_tgt);
        chk({tag, " R5 width"}, int'(final_width), err_exp ? 0 : (chg_at > 0 ? w2 : w1));
        @(negedge clk);
        chk({tag, " R9 done pulse"}, int'(done), 0);
        chk({tag, " R10 busy low"}, int'(busy), 0);
        repeat (d + 4) @(negedge clk);
        chk({tag, " R9 hold speed"}, int'(final_speed), err_exp ? 0 : exp_tgt);
        chk({tag, " R9 hold error"}, int'(error), int'(err_exp));
    endtask

    initial begin
        void'($urandom(32'h1A2B3C));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset values
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 error", int'(error), 0);
        chk("R1 speed", int'(final_speed), 0);
        chk("R1 width", int'(final_width), 0);
        chk("R1 target", int'(target_speed), 1);
        chk("R1 fts", int'(fts_count), 0);

        // R2 capability not Gen2: fields untouched, link stays Gen1
        run(1, 3, 4, 0, 0, 1'b0, "gen1");
        run(2, 0, 8, 0, 0, 1'b0, "gen2 d0");
        // R5 width changed after pass one completes
        run(2, 10, 4, 16, 17, 1'b0, "R5 chg");
        // R8 stray start mid-run
        run(3, 7, 2, 0, 0, 1'b1, "R8 restart");
        // R7 timeout boundary
        run(2, TMO - 2, 1, 0, 0, 1'b0, "R7 edge ok");
        run(2, TMO - 1, 1, 0, 0, 1'b0, "R7 edge tmo");
        // random mix
        for (int i = 0; i < 20; i++) begin
            run(int'($urandom_range(0, 3)), int'($urandom_range(0, 40)),
                int'($urandom_range(1, 16)), 0, 0, 1'b0, "rand");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        wd_hit = 1'b1;
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule